// File: doc/BRIEF.md
# Trace-driven request generator

This block stands in for a processor when a cache hierarchy is exercised in isolation. It holds a small table of memory accesses, each an address paired with a two-bit access kind, and plays the table out as a stream of requests. Only one request is ever in flight: a request is offered with a valid/ready handshake, and the block then waits for a one-cycle completion reply before it looks up the next entry. A fixed issue delay separates each reply from the next lookup.

The table is loaded from a parameter vector every time reset is held, so a run always starts again from entry 0. A terminate entry ends the run with a one-cycle `done` pulse and issues no request. A trace with no terminate entry wraps from the last entry back to entry 0. A cycle-limit watchdog ends such a run with a one-cycle `timeout` pulse. After either pulse the block stays idle until the next reset.

Top module: `trace_req_gen`

## Requirements
- R1: Entry i of the table sits in TRACE bits [i*(ADDR_W+2) +: ADDR_W+2]. The low ADDR_W bits are the address and the top two bits are the kind: 00 read, 01 write, 11 terminate, and 10 is treated as read. On the first clock edge after reset is released, `req_valid` rises with entry 0's address, and `req_write` is 1 exactly when the kind is 01.
- R2: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_write` hold their values on the next cycle. The only exception is a cycle in which `timeout` is raised.
- R3: Entries are issued in table order. After a handshake, `req_valid` stays low until `rsp_valid` has been sampled high.
- R4: `rsp_valid` has no effect when no request is outstanding. A pending request stays offered unchanged, and the reply does not count toward it.
- R5: When `rsp_valid` is sampled at clock edge r, the next request becomes valid on edge r+ISSUE_DELAY+1.
- R6: A terminate entry produces no request. Instead `done` is high for exactly one cycle, in the cycle where that request would have appeared. After that, `req_valid`, `done` and `timeout` stay low until reset.
- R7: While `rst_n` is low, `req_valid`, `done` and `timeout` are low after each clock edge, and the table is reloaded from TRACE.
- R8: If no terminate entry has been reached, `timeout` is high for one cycle after clock edge MAX_CYCLES, counting edges since reset release. In that cycle any pending request is withdrawn, and the block then stays idle.
- R9: The watchdog stops counting once `done` has fired, so `timeout` never follows a completed run.
- R10: After the last table entry has been served, the next entry issued is entry 0.
- R11: If a terminate lookup and watchdog expiry fall on the same edge, only `done` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also reloads the table |
| req_valid | output | 1 | A request is offered |
| req_ready | input | 1 | The downstream cache accepts the request |
| req_addr | output | ADDR_W | Address of the offered request |
| req_write | output | 1 | 1 for a write, 0 for a read |
| rsp_valid | input | 1 | One-cycle completion reply for the outstanding request |
| done | output | 1 | One-cycle pulse: a terminate entry was reached |
| timeout | output | 1 | One-cycle pulse: the cycle limit expired first |

## Verification
The watchdog expiry and the terminate lookup can land on the same clock edge. The bench builds that collision with a two-entry trace (one read, then terminate), an issue delay of 1 and a cycle limit of 5. Because the request, reply and gap timing are fixed, the lookup of the terminate entry falls exactly on edge 5. The outcome is judged at the ports: `done` must pulse after edge 5 and `timeout` must never rise. A separate wrapping trace reaches expiry alone, which shows that the watchdog path does fire when nothing competes with it.

// File: rtl/trg_pkg.sv
// Shared types for the trace-driven request generator.
// Assumes: access kinds are two bits wide, and the encodings are fixed by the table layout.
package trg_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_SPARE = 2'b10,
        ACC_END   = 2'b11
    } acc_kind_t;

    typedef enum logic [2:0] {
        SQ_FETCH,
        SQ_REQ,
        SQ_WAIT,
        SQ_GAP,
        SQ_HALT
    } seq_state_t;

    // Only the write code marks a store; the spare code is handled as a read.
    function automatic logic kind_is_write(acc_kind_t k);
        return k == ACC_WRITE;
    endfunction

    function automatic logic kind_is_end(acc_kind_t k);
        return k == ACC_END;
    endfunction

endpackage

// File: rtl/trg_trace_rom.sv
// Trace table: DEPTH entries of {kind, address}.
// Every entry is reloaded from the TRACE parameter vector while reset is held.
// Assumes: rd_idx is always below DEPTH (the sequencer wraps it).
module trg_trace_rom
    import trg_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned IDX_W  = 4,
    parameter logic [DEPTH*(ADDR_W+KIND_W)-1:0] TRACE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output acc_kind_t         rd_kind,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int unsigned ENT_W = ADDR_W + KIND_W;

    logic [ENT_W-1:0] slots [DEPTH];
    logic [ENT_W-1:0] sel;

    // Reload every slot from the parameter image during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                slots[i] <= TRACE[i*ENT_W +: ENT_W];
            end
        end
    end

    // Asynchronous read of the slot that the sequencer points at.
    always_comb begin
        sel     = slots[rd_idx];
        rd_kind = acc_kind_t'(sel[ENT_W-1 -: KIND_W]);
        rd_addr = sel[ADDR_W-1:0];
    end

endmodule

// File: rtl/trg_watchdog.sv
// Run-length watchdog: counts the edges while the sequencer is running.
// expire is high on the edge where the run reaches MAX_CYCLES.
// Assumes: MAX_CYCLES >= 2. The count freezes as soon as run drops.
module trg_watchdog #(
    parameter int unsigned MAX_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int unsigned CNT_W = $clog2(MAX_CYCLES) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_CYCLES - 1);

    logic [CNT_W-1:0] ticks;

    // Count the running edges; hold the count once halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks <= '0;
        end else if (run && !expire) begin
            ticks <= ticks + 1'b1;
        end
    end

    assign expire = run && (ticks == LAST);

endmodule

// File: rtl/trg_sequencer.sv
// Issue sequencer: fetches one entry at a time, offers it with valid/ready,
// waits for the reply, inserts the issue gap, then fetches the next entry.
// Assumes: one reply per accepted request. A terminate entry or watchdog expiry
// halts it until reset; the terminate lookup wins a tie with expiry.
module trg_sequencer
    import trg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned IDX_W       = 4,
    parameter int unsigned ISSUE_DELAY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_t         ent_kind,
    input  logic [ADDR_W-1:0] ent_addr,
    output logic [IDX_W-1:0]  idx,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic              expire,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_write,
    output logic              done,
    output logic              timeout,
    output logic              running
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    seq_state_t state;
    logic       end_now;
    logic       gap_done;
    logic       reply_take;

    assign end_now    = (state == SQ_FETCH) && kind_is_end(ent_kind);
    assign reply_take = (state == SQ_WAIT) && rsp_valid;
    assign req_valid  = (state == SQ_REQ);
    assign running    = (state != SQ_HALT);

    // The gap counter exists only when a non-zero issue delay is configured.
    generate
        if (ISSUE_DELAY > 0) begin : g_gap
            localparam int unsigned GAP_W = $clog2(ISSUE_DELAY + 1);
            localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(ISSUE_DELAY - 1);
            logic [GAP_W-1:0] gap_cnt;

            // Load the gap on a reply, then count down while in the gap state.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    gap_cnt <= '0;
                end else if (reply_take) begin
                    gap_cnt <= GAP_LOAD;
                end else if (state == SQ_GAP && gap_cnt != '0) begin
                    gap_cnt <= gap_cnt - 1'b1;
                end
            end

            assign gap_done = (state == SQ_GAP) && (gap_cnt == '0);
        end else begin : g_nogap
            assign gap_done = 1'b0;
        end
    endgenerate

    // Main issue state machine with the watchdog override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_FETCH;
            idx       <= '0;
            req_addr  <= '0;
            req_write <= 1'b0;
            done      <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            case (state)
                SQ_FETCH: begin
                    if (end_now) begin
                        state <= SQ_HALT;
                        done  <= 1'b1;
                    end else begin
                        state     <= SQ_REQ;
                        req_addr  <= ent_addr;
                        req_write <= kind_is_write(ent_kind);
                    end
                end
                SQ_REQ: begin
                    if (req_ready) begin
                        state <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (rsp_valid) begin
                        idx   <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
                        state <= (ISSUE_DELAY == 0) ? SQ_FETCH : SQ_GAP;
                    end
                end
                SQ_GAP: begin
                    if (gap_done) begin
                        state <= SQ_FETCH;
                    end
                end
                default: begin
                    state <= SQ_HALT;
                end
            endcase
            if (expire && !end_now) begin
                state   <= SQ_HALT;
                timeout <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/trace_req_gen.sv
// Trace-driven request generator top: table, sequencer and watchdog.
// Assumes: the downstream side returns exactly one rsp_valid pulse per accepted
// request. TRACE packs entry i at bits [i*(ADDR_W+2) +: ADDR_W+2], kind on top.
module trace_req_gen #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned ISSUE_DELAY = 1,
    parameter int unsigned MAX_CYCLES  = 100000,
    parameter logic [DEPTH*(ADDR_W+2)-1:0] TRACE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_write,
    input  logic              rsp_valid,
    output logic              done,
    output logic              timeout
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    trg_pkg::acc_kind_t ent_kind;
    logic [ADDR_W-1:0]  ent_addr;
    logic [IDX_W-1:0]   idx;
    logic               expire;
    logic               running;

    trg_trace_rom #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .TRACE  (TRACE)
    ) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (idx),
        .rd_kind (ent_kind),
        .rd_addr (ent_addr)
    );

    trg_sequencer #(
        .ADDR_W      (ADDR_W),
        .DEPTH       (DEPTH),
        .IDX_W       (IDX_W),
        .ISSUE_DELAY (ISSUE_DELAY)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_kind  (ent_kind),
        .ent_addr  (ent_addr),
        .idx       (idx),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .expire    (expire),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .done      (done),
        .timeout   (timeout),
        .running   (running)
    );

    trg_watchdog #(
        .MAX_CYCLES (MAX_CYCLES)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .expire (expire)
    );

endmodule

// File: rtl/trg_checker.sv
// Protocol checker for trace_req_gen, attached by bind.
// It keeps its own record of the outstanding request, the end of the run and the
// run length, and checks the ports against them.
module trg_checker #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned MAX_CYCLES = 100000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              done,
    input logic              timeout
);

    localparam int unsigned CW = $clog2(MAX_CYCLES + 1) + 1;

    logic          outstanding;
    logic          ended;
    logic [CW-1:0] run_cnt;

    // Track the outstanding request, the end of the run and the running edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            ended       <= 1'b0;
            run_cnt     <= '0;
        end else begin
            if (req_valid && req_ready) outstanding <= 1'b1;
            else if (rsp_valid)         outstanding <= 1'b0;
            if (done || timeout)        ended <= 1'b1;
            if (!ended && !done && !timeout) run_cnt <= run_cnt + 1'b1;
        end
    end

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (timeout || (req_valid && $stable(req_addr) && $stable(req_write))));

    a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !req_valid);

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        ended |-> (!req_valid && !done && !timeout));

    a_r11_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    a_r8_timeout_on_time: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (run_cnt == CW'(MAX_CYCLES)));

    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == CW'(MAX_CYCLES) && !ended) |-> (done || timeout));

endmodule

bind trace_req_gen trg_checker #(
    .ADDR_W     (ADDR_W),
    .MAX_CYCLES (MAX_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .done      (done),
    .timeout   (timeout)
);

// File: tb/trace_req_gen_bench.sv
// Directed bench: one task per scenario, three instances with their own traces.
module trace_req_gen_bench;

    localparam int AW = 16;

    function automatic logic [AW+1:0] ent(input logic [1:0] k, input logic [AW-1:0] a);
        return {k, a};
    endfunction

    localparam int D_A = 2;
    localparam logic [16*(AW+2)-1:0] TRACE_A = {
        {10{ent(2'b00, 16'h0AA0)}}, ent(2'b11, 16'h0000), ent(2'b01, 16'h0050),
        ent(2'b00, 16'h0040), ent(2'b10, 16'h0000), ent(2'b01, 16'h0010), ent(2'b00, 16'h0010)};
    localparam logic [4*(AW+2)-1:0] TRACE_B = {
        ent(2'b00, 16'h010C), ent(2'b00, 16'h0108), ent(2'b01, 16'h0104), ent(2'b00, 16'h0100)};
    localparam logic [2*(AW+2)-1:0] TRACE_C = {ent(2'b11, 16'h0000), ent(2'b00, 16'h0200)};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic a_rst_n = 1'b0, a_ready = 1'b0, a_rsp = 1'b0;
    logic a_valid, a_write, a_done, a_timeout;
    logic [AW-1:0] a_addr;
    logic b_rst_n = 1'b0, b_ready = 1'b0, b_rsp = 1'b0;
    logic b_valid, b_write, b_done, b_timeout;
    logic [AW-1:0] b_addr;
    logic c_rst_n = 1'b0, c_ready = 1'b0, c_rsp = 1'b0;
    logic c_valid, c_write, c_done, c_timeout;
    logic [AW-1:0] c_addr;

    trace_req_gen #(.ADDR_W(AW), .DEPTH(16), .ISSUE_DELAY(D_A), .MAX_CYCLES(1000), .TRACE(TRACE_A))
    u_trace_req_gen (
        .clk(clk), .rst_n(a_rst_n), .req_valid(a_valid), .req_ready(a_ready), .req_addr(a_addr),
        .req_write(a_write), .rsp_valid(a_rsp), .done(a_done), .timeout(a_timeout));

    trace_req_gen #(.ADDR_W(AW), .DEPTH(4), .ISSUE_DELAY(0), .MAX_CYCLES(40), .TRACE(TRACE_B))
    u_trace_req_gen_wrap (
        .clk(clk), .rst_n(b_rst_n), .req_valid(b_valid), .req_ready(b_ready), .req_addr(b_addr),
        .req_write(b_write), .rsp_valid(b_rsp), .done(b_done), .timeout(b_timeout));

    trace_req_gen #(.ADDR_W(AW), .DEPTH(2), .ISSUE_DELAY(1), .MAX_CYCLES(5), .TRACE(TRACE_C))
    u_trace_req_gen_tie (
        .clk(clk), .rst_n(c_rst_n), .req_valid(c_valid), .req_ready(c_ready), .req_addr(c_addr),
        .req_write(c_write), .rsp_valid(c_rsp), .done(c_done), .timeout(c_timeout));

    // Record one check; print a FAIL line on mismatch.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // R7: outputs quiet while reset is held.
    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        chk("R7 valid in reset", 32'(a_valid), 0);
        chk("R7 done in reset", 32'(a_done), 0);
        chk("R7 timeout in reset", 32'(a_timeout), 0);
        a_rst_n = 1'b1;
    endtask

    // R1: the first request appears one edge after release.
    task automatic t_first_request();
        @(negedge clk);
        chk("R1 first valid", 32'(a_valid), 1);
        chk("R1 first addr", 32'(a_addr), 32'h0010);
        chk("R1 first write", 32'(a_write), 0);
    endtask

    // R2/R4: hold without ready, spurious reply ignored; R3: no issue before the reply.
    task automatic t_hold_and_spurious();
        a_rsp = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            a_rsp = 1'b0;
            chk("R2 held valid", 32'(a_valid), 1);
            chk("R4 addr after spurious reply", 32'(a_addr), 32'h0010);
        end
        a_ready = 1'b1;
        @(negedge clk);
        a_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3 no issue before reply", 32'(a_valid), 0);
        end
    endtask

    // R5: reply, then measure the gap and check the next entry.
    task automatic t_serve(input logic [AW-1:0] exp_addr, input logic exp_wr);
        int k = 0;
        a_rsp = 1'b1;
        @(negedge clk);
        a_rsp = 1'b0;
        while (!a_valid && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk("R5 issue gap", 32'(k), 32'(D_A + 1));
        chk("R3 entry addr", 32'(a_addr), 32'(exp_addr));
        chk("R1 entry write flag", 32'(a_write), 32'(exp_wr));
    endtask

    // R2: hand over after a number of stall cycles.
    task automatic t_handshake(input int stall);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk("R2 valid during stall", 32'(a_valid), 1);
        end
        a_ready = 1'b1;
        @(negedge clk);
        a_ready = 1'b0;
    endtask

    // R6/R9: terminate produces a done pulse, then silence past the cycle limit.
    task automatic t_terminate();
        int k = 0;
        int noise = 0;
        a_rsp = 1'b1;
        @(negedge clk);
        a_rsp = 1'b0;
        while (!a_done && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk("R6 done timing", 32'(k), 32'(D_A + 1));
        chk("R6 no request for terminate", 32'(a_valid), 0);
        @(negedge clk);
        chk("R6 done one cycle", 32'(a_done), 0);
        a_ready = 1'b1;
        for (int i = 0; i < 1100; i++) begin
            a_rsp = i[0];
            @(negedge clk);
            if (a_valid || a_done) noise++;
            if (a_timeout) noise += 1000;
        end
        a_rsp = 1'b0;
        chk("R6 idle after done", 32'(noise % 1000), 0);
        chk("R9 no timeout after done", 32'(noise / 1000), 0);
    endtask

    // R8/R10: wrapping trace without terminate ends on the watchdog.
    task automatic t_wrap_timeout();
        logic pend = 1'b0;
        int nreq = 0;
        int t_at = 0;
        int late = 0;
        logic [AW-1:0] addr4 = '0;
        logic [AW-1:0] addr5 = '0;
        logic wr2 = 1'b0;
        b_ready = 1'b1;
        b_rst_n = 1'b1;
        for (int n = 1; n <= 60; n++) begin
            @(negedge clk);
            b_rsp = pend;
            pend = 1'b0;
            if (b_done) late += 100;
            if (b_timeout) begin
                if (t_at == 0) begin
                    t_at = n;
                    chk("R8 request withdrawn", 32'(b_valid), 0);
                end else late++;
            end
            if (b_valid) begin
                if (t_at != 0) late++;
                nreq++;
                pend = 1'b1;
                if (nreq == 2) wr2 = b_write;
                if (nreq == 4) addr4 = b_addr;
                if (nreq == 5) addr5 = b_addr;
            end
        end
        b_rsp = 1'b0;
        chk("R8 timeout edge", 32'(t_at), 40);
        chk("R8 idle after timeout", 32'(late), 0);
        chk("R8 request count", 32'(nreq), 13);
        chk("R10 last entry", 32'(addr4), 32'h010C);
        chk("R10 wrap to entry 0", 32'(addr5), 32'h0100);
        chk("R1 write code", 32'(wr2), 1);
    endtask

    // R11: terminate lookup and watchdog expiry on the same edge.
    task automatic t_tie();
        logic pend = 1'b0;
        int d_at = 0;
        int t_seen = 0;
        c_ready = 1'b1;
        c_rst_n = 1'b1;
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            c_rsp = pend;
            pend = 1'b0;
            if (c_valid) pend = 1'b1;
            if (c_done && d_at == 0) d_at = n;
            if (c_timeout) t_seen++;
        end
        c_rsp = 1'b0;
        chk("R11 done at tie edge", 32'(d_at), 5);
        chk("R11 timeout suppressed", 32'(t_seen), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_first_request();
        t_hold_and_spurious();
        t_serve(16'h0010, 1'b1);
        t_handshake(0);
        t_serve(16'h0000, 1'b0);
        t_handshake(2);
        t_serve(16'h0040, 1'b0);
        t_handshake(1);
        t_serve(16'h0050, 1'b1);
        t_handshake(0);
        t_terminate();
        t_wrap_timeout();
        t_tie();
        summary();
        $finish;
    end

endmodule